// File: doc/BRIEF.md
# Addressable Bit Latch with Decoder Mode

This block is an eight-position bit register. Each write stores a single data bit, and a binary address picks the position that receives it. Each stored bit drives its own output line, so the whole word is always visible in parallel. Two active-low control pins choose the operating mode on every rising clock edge: the enable pin and the clear pin. The four modes are addressed write, hold, clear, and a one-hot demultiplex mode. In demultiplex mode the addressed bit takes the data value and every other bit is driven low.

All storage is built from rising-edge flip-flops, so every result appears one clock after the inputs that cause it. An active-high synchronous power-on reset empties the register. This reset is separate from the clear pin. The register can act as a serial-to-parallel converter: write one bit per cycle at addresses 0, 1, 2 and so on, and the word builds up on the outputs. It can also act as a 1-of-N decoder: hold the data bit high and use demultiplex mode. The address should change only while enable is inactive. Write-mode cycles then never see an address that is still settling.

Top module: `alm_bitlatch`

## Requirements
- R1: When `rst` is high at a rising edge, all outputs are 0 after that edge, whatever the other inputs are.
- R2: Write mode is `clr_n`=1 and `en_n`=0. In this mode, output bit number `addr` (bit i sits at output position i) equals `din` after the edge.
- R3: In write mode, every output bit other than the addressed one keeps its previous value.
- R4: Hold mode is `clr_n`=1 and `en_n`=1. In this mode, all outputs keep their previous values, whatever `din` and `addr` are.
- R5: Demultiplex mode is `clr_n`=0 and `en_n`=0. In this mode, output bit `addr` equals `din` after the edge and all other bits are 0.
- R6: A one-hot (or all-zero) word left by demultiplex mode stays on the outputs through following hold-mode cycles.
- R7: Clear mode is `clr_n`=0 and `en_n`=1. In this mode, all outputs are 0 after the edge, whatever `din` and `addr` are.
- R8: Eight back-to-back write cycles at addresses 0 through 7 leave output bit i equal to the data bit that was written in the i-th of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| din | input | 1 | Data bit to store or route |
| addr | input | ADDR_W | Selected bit position |
| en_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Clear control, active low |
| q | output | 2**ADDR_W | Parallel register content |

## Verification
The bench builds the block with its default ADDR_W of 3, which gives eight positions. Every address can therefore be driven in all four modes, and a full serial fill fits in eight cycles. A behavioural reference word is updated on each clock and compared with the outputs on every cycle. The stimulus covers several fill patterns, hold and clear cycles with deliberately noisy data and address inputs, one-hot words held after demultiplexing, and a power-on reset issued during a write.

// File: rtl/alm_pkg.sv
package alm_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alm_mode_e;

  function automatic alm_mode_e mode_of(input logic en_n, input logic clr_n);
    alm_mode_e m;
    unique case ({clr_n, en_n})
      2'b11:   m = MODE_HOLD;
      2'b10:   m = MODE_WRITE;
      2'b00:   m = MODE_DEMUX;
      default: m = MODE_CLEAR;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/alm_mode_dec.sv
module alm_mode_dec
  import alm_pkg::*;
(
  input  logic      en_n,
  input  logic      clr_n,
  output alm_mode_e mode
);

  always_comb mode = mode_of(en_n, clr_n);

endmodule

// File: rtl/alm_addr_dec.sv
module alm_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);

  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/alm_cell.sv
module alm_cell
  import alm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  alm_mode_e mode,
  input  logic      sel,
  input  logic      din,
  output logic      q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    unique case (mode)
      MODE_WRITE: if (sel) q_nxt = din;
      MODE_DEMUX: q_nxt = sel & din;
      MODE_CLEAR: q_nxt = 1'b0;
      default:    q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

  // R4
  cell_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_HOLD |=> $stable(q));

  // R3
  cell_unsel_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE && !sel) |=> $stable(q));

endmodule

// File: rtl/alm_bitlatch.sv
module alm_bitlatch
  import alm_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              clr_n,
  output logic [NBITS-1:0]  q
);

  alm_mode_e        mode;
  logic [NBITS-1:0] sel;

  alm_mode_dec u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  alm_addr_dec #(.ADDR_W(ADDR_W)) u_adec (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    alm_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .sel  (sel[i]),
      .din  (din),
      .q    (q[i])
    );
  end

  // R1
  por_clear_chk: assert property (@(posedge clk)
    rst |=> q == '0);

  // R2
  write_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> q[$past(addr)] == $past(din));

  // R3
  write_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr_n) |=> $countones(q ^ $past(q)) <= 1);

  // R5
  demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> ($countones(q) <= 1 && q[$past(addr)] == $past(din)));

  // R6
  demux_persist_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n && $past(!en_n && !clr_n)) |=> $countones(q) <= 1);

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> q == '0);

endmodule

// File: tb/test_alm_bitlatch.sv
module test_alm_bitlatch;

  logic       clk = 1'b0;
  logic       rst;
  logic       din;
  logic [2:0] addr;
  logic       en_n;
  logic       clr_n;
  logic [7:0] q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  alm_bitlatch i_alm_bitlatch (
    .clk(clk), .rst(rst), .din(din), .addr(addr),
    .en_n(en_n), .clr_n(clr_n), .q(q)
  );

  task automatic step(input logic r, input logic d, input int a,
                      input logic e, input logic c, input string tag);
    rst = r; din = d; addr = a[2:0]; en_n = e; clr_n = c;
    @(posedge clk);
    if (r) model = 8'h00;
    else if (c && !e) model[a] = d;
    else if (!c && !e) begin model = 8'h00; model[a] = d; end
    else if (!c && e) model = 8'h00;
    @(negedge clk);
    checks++;
    if (q !== model) begin
      errors++;
      $display("FAIL %s q=%b expected=%b", tag, q, model);
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog q=%b expected=%b", q, model);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] pat;
    model = 8'h00;
    rst = 1'b1; din = 1'b1; addr = 3'd0; en_n = 1'b0; clr_n = 1'b1;
    @(negedge clk);
    step(1, 1, 3, 0, 1, "R1");
    step(1, 0, 5, 1, 1, "R1");
    for (int a = 0; a < 8; a++) step(0, 1, a, 0, 1, "R2");
    for (int a = 0; a < 8; a++) step(0, a[0], 7 - a, 1, 1, "R4");
    for (int a = 1; a < 8; a += 2) step(0, 0, a, 0, 1, "R3");
    for (int a = 0; a < 8; a++) begin
      step(0, a[1] | a[0], a, 0, 0, "R5");
      step(0, ~a[0], (a + 3) % 8, 1, 1, "R6");
      step(0, a[0], (a + 5) % 8, 1, 1, "R6");
    end
    for (int a = 0; a < 8; a++) step(0, 1, a, 0, 1, "R2");
    for (int a = 0; a < 8; a++) step(0, 1, a, 1, 0, "R7");
    pat = 8'b1011_0010;
    for (int a = 0; a < 8; a++) step(0, pat[a], a, 0, 1, "R8");
    step(0, 0, 2, 1, 1, "R8");
    pat = 8'h6D;
    for (int a = 0; a < 8; a++) step(0, pat[a], a, 0, 1, "R8");
    checks++;
    if (q !== pat) begin
      errors++;
      $display("FAIL R8 q=%b expected=%b", q, pat);
    end
    step(1, 1, 4, 0, 1, "R1");
    step(0, 1, 6, 1, 1, "R1");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule